// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block keeps every in-flight load of an out-of-order core in a small circular queue, ordered exactly as the loads were dispatched. A load claims the slot at the tail when it dispatches and receives a pointer that carries a wrap bit. It fills in its address when it executes. It frees its slot from the head when it retires. A store reads the same pointer at its own dispatch and keeps it as its position in the load stream.

When the store later executes, it presents its address and that saved position. The queue compares the address against every executed load at once. Loads dispatched before the store are ignored. Of the remaining matching loads, the one closest to the store in program order is chosen. One cycle later the block raises a violation flag and gives that load's reorder-buffer tag, so the core can mark it for an exception and restart from it at commit. A flush empties the whole queue in a single cycle.

Top module: `lq_order_check`

## Requirements
- R1: After reset the queue is empty, `full` is low, `disp_ptr` is 0 and `viol_valid` is low.
- R2: A dispatch accepted while the queue is not full writes the tag to the slot `disp_ptr[IDX_W-1:0]` and advances `disp_ptr` by one modulo 2*DEPTH; the top bit of `disp_ptr` is the wrap bit. When DEPTH entries are held, `full` is high and a dispatch leaves `disp_ptr` unchanged.
- R3: Retire removes the oldest entry and clears `full`; a retire while the queue is empty has no effect.
- R4: A store search with address A and position P sets `viol_valid` in the cycle after the search, with `viol_tag` equal to the tag of a matching load. A matching load is one that is held, has executed with address A, and was dispatched at or after P.
- R5: Loads dispatched before the store position, meaning their offset from the head is below P minus head, are never reported, whatever their address.
- R6: A held load that has not executed since its dispatch is never reported, even if its slot held address A for an earlier occupant.
- R7: When several loads match, the one reported is the oldest of them in dispatch order.
- R8: Age order, matching and selection stay correct for every head position, including after the pointers wrap.
- R9: Flush empties the queue in one cycle, after which `disp_ptr` is 0. A search in the same cycle as a flush produces no violation.
- R10: A load executing in the same cycle as a store search takes part in that search with its new address.
- R11: `viol_valid` is low in every cycle that does not follow a store search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Allocate an entry for a dispatching load |
| disp_tag | input | TAG_W | Reorder-buffer tag of the dispatching load |
| disp_ptr | output | IDX_W+1 | Current tail with wrap bit: slot given to the next load, and the position a dispatching store saves |
| full | output | 1 | All entries held; dispatch blocked |
| empty | output | 1 | No entries held |
| exe_valid | input | 1 | A load has resolved its address |
| exe_slot | input | IDX_W | Slot of the executing load |
| exe_addr | input | ADDR_W | Address of the executing load |
| st_valid | input | 1 | A store executes and searches the queue |
| st_addr | input | ADDR_W | Address of the store |
| st_pos | input | IDX_W+1 | Tail pointer the store saved at its dispatch |
| ret_valid | input | 1 | Retire the head entry |
| flush | input | 1 | Empty the whole queue |
| viol_valid | output | 1 | Ordering violation found by the previous search |
| viol_tag | output | TAG_W | Tag of the oldest offending load |

## Verification
The two functions that can meet in one cycle are a load writing its address and a store searching the queue. They can also meet a flush. The bench drives a load's execute and a matching store search on the same clock edge. It expects the fresh address to produce a violation one cycle later. It also drives a flush together with a search that would hit, and expects neither a violation nor any remaining entry. Around these cases a sweep covers every head rotation, every set of matching slots and every store position, and the bench computes the oldest younger match by arithmetic for each.

// File: rtl/lq_order_check.sv
module lq_order_check #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  input  logic [TAG_W-1:0]          disp_tag,
  output logic [$clog2(DEPTH):0]    disp_ptr,
  output logic                      full,
  output logic                      empty,
  input  logic                      exe_valid,
  input  logic [$clog2(DEPTH)-1:0]  exe_slot,
  input  logic [ADDR_W-1:0]         exe_addr,
  input  logic                      st_valid,
  input  logic [ADDR_W-1:0]         st_addr,
  input  logic [$clog2(DEPTH):0]    st_pos,
  input  logic                      ret_valid,
  input  logic                      flush,
  output logic                      viol_valid,
  output logic [TAG_W-1:0]          viol_tag
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0]  head_q, tail_q, cnt, sdist;
  logic [DEPTH-1:0]  av_q, cand;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic              hit;
  logic [TAG_W-1:0]  hit_tag;

  assign cnt      = tail_q - head_q;
  assign sdist    = st_pos - head_q;
  assign full     = cnt == PTR_W'(DEPTH);
  assign empty    = cnt == '0;
  assign disp_ptr = tail_q;

  wire do_disp = disp_valid && !full;
  wire do_ret  = ret_valid && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wire [IDX_W-1:0]  off  = IDX_W'(g) - head_q[IDX_W-1:0];
    wire              byp  = exe_valid && exe_slot == IDX_W'(g);
    wire [ADDR_W-1:0] eadr = byp ? exe_addr : addr_q[g];
    wire              evld = byp || av_q[g];
    assign cand[g] = ({1'b0, off} < cnt) && ({1'b0, off} >= sdist)
                     && evld && eadr == st_addr;
  end

  always_comb begin
    hit     = 1'b0;
    hit_tag = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!hit && cand[IDX_W'(head_q[IDX_W-1:0] + IDX_W'(k))]) begin
        hit     = 1'b1;
        hit_tag = tag_q[IDX_W'(head_q[IDX_W-1:0] + IDX_W'(k))];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q     <= '0;
      tail_q     <= '0;
      av_q       <= '0;
      viol_valid <= 1'b0;
    end else begin
      if (exe_valid) begin
        addr_q[exe_slot] <= exe_addr;
        av_q[exe_slot]   <= 1'b1;
      end
      if (do_ret) begin
        av_q[head_q[IDX_W-1:0]] <= 1'b0;
        head_q <= head_q + 1'b1;
      end
      if (do_disp) begin
        tag_q[tail_q[IDX_W-1:0]] <= disp_tag;
        av_q[tail_q[IDX_W-1:0]]  <= 1'b0;
        tail_q <= tail_q + 1'b1;
      end
      viol_valid <= st_valid && hit;
      if (st_valid && hit) viol_tag <= hit_tag;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && full && !flush) |=> $stable(disp_ptr));

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !full && !flush) |=> disp_ptr == PTR_W'($past(disp_ptr) + 1'b1));

  a_r3_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && empty && !disp_valid && !flush) |=> empty);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !viol_valid));

  a_r11_viol_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(st_valid));
endmodule

// File: tb/tb_lq_order_check.sv
`timescale 1ns/1ps
module tb_lq_order_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic [5:0] disp_tag = '0;
  logic [2:0] disp_ptr;
  logic       full, empty;
  logic       exe_valid = 1'b0;
  logic [1:0] exe_slot = '0;
  logic [7:0] exe_addr = '0;
  logic       st_valid = 1'b0;
  logic [7:0] st_addr = '0;
  logic [2:0] st_pos = '0;
  logic       ret_valid = 1'b0;
  logic       flush = 1'b0;
  logic       viol_valid;
  logic [5:0] viol_tag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lq_order_check #(.DEPTH(4), .ADDR_W(8), .TAG_W(6)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [5:0] tag, output logic [2:0] ptr);
    ptr = disp_ptr;
    disp_valid = 1'b1; disp_tag = tag;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic execute(input logic [1:0] slot, input logic [7:0] a);
    exe_valid = 1'b1; exe_slot = slot; exe_addr = a;
    @(negedge clk);
    exe_valid = 1'b0;
  endtask

  task automatic retire();
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic search(input logic [7:0] a, input logic [2:0] pos);
    st_valid = 1'b1; st_addr = a; st_pos = pos;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] p [4];
    logic [2:0] tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 disp_ptr", disp_ptr, 0);
    check("R1 viol_valid", viol_valid, 0);

    // R2 fill and block
    for (int k = 0; k < 4; k++) begin
      dispatch(6'(k + 1), tmp);
      check("R2 returned ptr", tmp, k);
    end
    check("R2 full", full, 1);
    dispatch(6'd9, tmp);
    check("R2 blocked ptr stable", disp_ptr, 4);
    retire();
    check("R3 full cleared", full, 0);
    dispatch(6'd10, tmp);
    check("R2 ptr after free", disp_ptr, 5);

    // R9 flush
    do_flush();
    check("R9 empty", empty, 1);
    check("R9 ptr zero", disp_ptr, 0);

    // R3 retire on empty ignored
    retire();
    check("R3 empty retire ptr", disp_ptr, 0);
    check("R3 empty retire empty", empty, 1);

    // R10 execute and search in the same cycle
    dispatch(6'd7, tmp);
    exe_valid = 1'b1; exe_slot = 2'd0; exe_addr = 8'h5A;
    st_valid = 1'b1; st_addr = 8'h5A; st_pos = 3'd0;
    @(negedge clk);
    exe_valid = 1'b0; st_valid = 1'b0;
    check("R10 same-cycle viol", viol_valid, 1);
    check("R10 same-cycle tag", viol_tag, 7);

    // R9 flush with a hitting search
    flush = 1'b1; st_valid = 1'b1; st_addr = 8'h5A; st_pos = 3'd0;
    @(negedge clk);
    flush = 1'b0; st_valid = 1'b0;
    check("R9 flush suppresses viol", viol_valid, 0);
    check("R9 flush empties", empty, 1);

    // R4 R5 R6 R7 R8 sweep over rotation, match mask, store position
    for (int rot = 0; rot < 8; rot++) begin
      for (int mask = 0; mask < 16; mask++) begin
        do_flush();
        for (int r = 0; r < rot; r++) begin
          dispatch(6'd63, tmp);
          execute(tmp[1:0], 8'h5A);
          retire();
        end
        for (int k = 0; k < 4; k++) dispatch(6'(rot * 4 + k + 1), p[k]);
        for (int k = 0; k < 4; k++) begin
          if (mask[k]) execute(p[k][1:0], 8'h5A);
          else if (k % 2 == 0) execute(p[k][1:0], 8'hC3);
        end
        for (int sd = 0; sd <= 4; sd++) begin
          int exp_k;
          exp_k = -1;
          for (int k = 3; k >= sd; k--) if (mask[k]) exp_k = k;
          search(8'h5A, 3'(rot + sd));
          check("R4 R5 R6 R8 viol_valid", viol_valid, exp_k >= 0);
          if (exp_k >= 0) check("R7 R8 oldest younger tag", viol_tag, rot * 4 + exp_k + 1);
          @(negedge clk);
          check("R11 no search no viol", viol_valid, 0);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule